// File: doc/BRIEF.md
# Asynchronous Character Receiver

This block recovers characters from an asynchronous serial line. A sample tick supplied from outside defines the sampling rate. A divisor field selects whether one tick, sixteen ticks or sixty-four ticks make one bit time. The format inputs select a word length of 5 to 8 bits and optional odd or even parity. Each completed character lands in a single holding register. A ready flag stays up until the host acknowledges a read.

Receive errors are kept in sticky flags that only an error-reset pulse clears. These cover bad parity, a missing stop bit, and a character that overwrote an unread one. The block also raises a break flag when a whole frame arrives as zeros. A receive-enable input gates the search for new frames. When the enable drops, any frame in progress is abandoned.

Top module: `async_char_rx`

## Requirements
- R1: After reset the ready flag, all four error/break flags and the data output are 0.
- R2: Word-length code `len_sel` selects 5, 6, 7 or 8 data bits for codes 00, 01, 10, 11. Bits arrive least significant first and are zero-extended to 8 bits on `rx_data`.
- R3: Divisor code `div_sel` selects the ticks per bit: 01 gives 1, 10 gives 16 and 11 gives 64. With code 00 no frame is ever accepted.
- R4: With 16 or 64 ticks per bit, a low level that is no longer low half a bit time after it was first seen is rejected as a glitch and produces no character.
- R5: `rx_ready` goes to 1 the cycle after a character completes and returns to 0 the cycle after an `rd_ack` pulse when no character completes at the same time.
- R6: If a character completes while `rx_ready` is 1 and no `rd_ack` is present, the new character replaces the held one and `err_overrun` is set.
- R7: `err_frame` is set when the line is low at the stop-bit sample point.
- R8: When `par_en` is 1, one parity bit follows the data. `par_even`=1 demands an even count of ones over data plus parity, and 0 demands an odd count. A mismatch sets `err_parity`. With `par_en`=0 no parity bit is expected and `err_parity` is never set.
- R9: `brk_det` is set when start bit, data bits, parity bit (if enabled) and the stop bit are all sampled low.
- R10: The parity, overrun, framing and break flags stay set across reads and later good characters, and are cleared only by an `err_clr` pulse.
- R11: While `rx_en` is 0 no frame is accepted. A frame in progress when `rx_en` falls is discarded and never sets `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| smp_tick | input | 1 | One-cycle sample strobe at the oversampling rate |
| len_sel | input | 2 | Word length code |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Parity sense: 1 even, 0 odd |
| div_sel | input | 2 | Ticks-per-bit code |
| rx_en | input | 1 | Receive enable |
| rd_ack | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clears the sticky error and break flags |
| rx_data | output | 8 | Received character, zero-extended |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_frame | output | 1 | Sticky framing error |
| brk_det | output | 1 | Sticky break detect |

## Verification
The bound checker follows the handoff from the frame engine to the holding register on every cycle. It checks that the ready flag sets and clears, that the overrun flag rises and the data is replaced, that the error flags are sticky and clear only on `err_clr`, that the data is stable between completions, and that no completion appears while reception is disabled. Some behaviour shows only in the bench's serial scenarios, driven against its scoreboard: bit assembly for each word length and divisor, parity generation and checking for each sense, glitch rejection at mid start bit, break and framing detection, and the discarding of a frame cut off by the enable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;

   localparam logic [1:0] DIV_OFF = 2'b00;
   localparam logic [1:0] DIV_X1  = 2'b01;
   localparam logic [1:0] DIV_MID = 2'b10;
   localparam logic [1:0] DIV_HI  = 2'b11;

   typedef struct packed {
      logic perr;
      logic ferr;
      logic brk;
   } rx_status_t;

endpackage

// File: rtl/rxf_line_sync.sv
module rxf_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = q[STAGES-1];
endmodule

// File: rtl/rxf_frame.sv
module rxf_frame
   import rxf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MIN_BITS  = 5,
   parameter int RATIO_MID = 16,
   parameter int RATIO_HI  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_s,
   input  logic              tick,
   input  logic              enable,
   input  logic [1:0]        len_code,
   input  logic [1:0]        div_code,
   input  logic              par_on,
   input  logic              par_even,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output rx_status_t        stat
);
   localparam int CNT_W = $clog2(RATIO_HI) + 1;
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lat_ratio;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic              lat_pen;
   logic              lat_pev;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              all_zero;

   function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] code);
      case (code)
         DIV_X1:  ratio_of = CNT_W'(1);
         DIV_MID: ratio_of = CNT_W'(RATIO_MID);
         DIV_HI:  ratio_of = CNT_W'(RATIO_HI);
         default: ratio_of = '0;
      endcase
   endfunction

   logic [CNT_W-1:0] half_pt;
   logic             at_sample;
   logic             at_half;
   logic             par_bad;

   assign half_pt   = lat_ratio >> 1;
   assign at_sample = (cnt == lat_ratio - CNT_W'(1));
   assign at_half   = (cnt == half_pt - CNT_W'(1));
   // even sense: the ones over data plus parity must be even
   assign par_bad   = lat_pen && ((^shreg ^ pbit) == lat_pev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         lat_ratio <= CNT_W'(1);
         idx       <= '0;
         last_idx  <= '0;
         lat_pen   <= 1'b0;
         lat_pev   <= 1'b0;
         shreg     <= '0;
         pbit      <= 1'b0;
         all_zero  <= 1'b0;
         done      <= 1'b0;
         data      <= '0;
         stat      <= '0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (tick) begin
            unique case (state)
               ST_IDLE: begin
                  if (!line_s && div_code != DIV_OFF) begin
                     lat_ratio <= ratio_of(div_code);
                     last_idx  <= IDX_W'(MIN_BITS - 1) + IDX_W'(len_code);
                     lat_pen   <= par_on;
                     lat_pev   <= par_even;
                     shreg     <= '0;
                     pbit      <= 1'b0;
                     idx       <= '0;
                     cnt       <= '0;
                     all_zero  <= 1'b1;
                     state     <= (div_code == DIV_X1) ? ST_DATA : ST_START;
                  end
               end
               ST_START: begin
                  if (at_half) begin
                     cnt   <= '0;
                     state <= line_s ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_DATA: begin
                  if (at_sample) begin
                     cnt        <= '0;
                     shreg[idx] <= line_s;
                     if (line_s) all_zero <= 1'b0;
                     idx <= idx + IDX_W'(1);
                     if (idx == last_idx) state <= lat_pen ? ST_PAR : ST_STOP;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_PAR: begin
                  if (at_sample) begin
                     cnt  <= '0;
                     pbit <= line_s;
                     if (line_s) all_zero <= 1'b0;
                     state <= ST_STOP;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_STOP: begin
                  if (at_sample) begin
                     cnt       <= '0;
                     done      <= 1'b1;
                     data      <= shreg;
                     stat.ferr <= !line_s;
                     stat.perr <= par_bad;
                     stat.brk  <= all_zero && !line_s;
                     state     <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold
   import rxf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data_in,
   input  rx_status_t        stat,
   input  logic              rd_ack,
   input  logic              err_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              ready,
   output logic              f_par,
   output logic              f_ovr,
   output logic              f_frm,
   output logic              f_brk
);
   logic ovr_evt;
   assign ovr_evt = done && ready && !rd_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ready  <= 1'b0;
      end else if (done) begin
         data_q <= data_in;
         ready  <= 1'b1;
      end else if (rd_ack) begin
         ready <= 1'b0;
      end
   end

   // a new event wins over a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_par <= 1'b0;
         f_ovr <= 1'b0;
         f_frm <= 1'b0;
         f_brk <= 1'b0;
      end else begin
         if (done && stat.perr) f_par <= 1'b1;
         else if (err_clr)      f_par <= 1'b0;
         if (ovr_evt)           f_ovr <= 1'b1;
         else if (err_clr)      f_ovr <= 1'b0;
         if (done && stat.ferr) f_frm <= 1'b1;
         else if (err_clr)      f_frm <= 1'b0;
         if (done && stat.brk)  f_brk <= 1'b1;
         else if (err_clr)      f_brk <= 1'b0;
      end
   end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
   import rxf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MIN_BITS    = 5,
   parameter int RATIO_MID   = 16,
   parameter int RATIO_HI    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              smp_tick,
   input  logic [1:0]        len_sel,
   input  logic              par_en,
   input  logic              par_even,
   input  logic [1:0]        div_sel,
   input  logic              rx_en,
   input  logic              rd_ack,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              err_parity,
   output logic              err_overrun,
   output logic              err_frame,
   output logic              brk_det
);
   generate
      if (MIN_BITS + 3 > DATA_W) begin : g_bad_width
         $error("DATA_W must hold the longest word length");
      end
      if (RATIO_MID < 2 || (RATIO_MID % 2) != 0) begin : g_bad_mid
         $error("RATIO_MID must be even and at least 2");
      end
      if (RATIO_HI <= RATIO_MID || (RATIO_HI % 2) != 0) begin : g_bad_hi
         $error("RATIO_HI must be even and above RATIO_MID");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              line_s;
   logic              frm_done;
   logic [DATA_W-1:0] frm_data;
   rx_status_t        frm_stat;
   logic              frm_perr;
   logic              frm_ferr;
   logic              frm_brk;

   assign frm_perr = frm_stat.perr;
   assign frm_ferr = frm_stat.ferr;
   assign frm_brk  = frm_stat.brk;

   rxf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (line_s)
   );

   rxf_frame #(
      .DATA_W   (DATA_W),
      .MIN_BITS (MIN_BITS),
      .RATIO_MID(RATIO_MID),
      .RATIO_HI (RATIO_HI)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_s  (line_s),
      .tick    (smp_tick),
      .enable  (rx_en),
      .len_code(len_sel),
      .div_code(div_sel),
      .par_on  (par_en),
      .par_even(par_even),
      .done    (frm_done),
      .data    (frm_data),
      .stat    (frm_stat)
   );

   rxf_hold #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (frm_done),
      .data_in(frm_data),
      .stat   (frm_stat),
      .rd_ack (rd_ack),
      .err_clr(err_clr),
      .data_q (rx_data),
      .ready  (rx_ready),
      .f_par  (err_parity),
      .f_ovr  (err_overrun),
      .f_frm  (err_frame),
      .f_brk  (brk_det)
   );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              rd_ack,
   input logic              err_clr,
   input logic              frm_done,
   input logic [DATA_W-1:0] frm_data,
   input logic              frm_perr,
   input logic              frm_ferr,
   input logic              frm_brk,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              err_parity,
   input logic              err_overrun,
   input logic              err_frame,
   input logic              brk_det
);
   a_r5_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> rx_ready);

   a_r5_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !frm_done |=> !rx_ready);

   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && rx_ready && !rd_ack |=> err_overrun && rx_data == $past(frm_data));

   a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> $stable(rx_data));

   a_r7_frame_set: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && frm_ferr |=> err_frame);

   a_r8_parity_set: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && frm_perr |=> err_parity);

   a_r9_break_set: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && frm_brk |=> brk_det);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> (err_parity >= $past(err_parity)) && (err_overrun >= $past(err_overrun))
                && (err_frame >= $past(err_frame)) && (brk_det >= $past(brk_det)));

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr && !frm_done |=> !err_parity && !err_overrun && !err_frame && !brk_det);

   a_r11_no_done_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !frm_done);
endmodule

bind async_char_rx rxf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_async_char_rx.sv
module sim_async_char_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       smp_tick = 1'b0;
   logic [1:0] len_sel = 2'b11;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic [1:0] div_sel = 2'b01;
   logic       rx_en = 1'b0;
   logic       rd_ack = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, err_parity, err_overrun, err_frame, brk_det;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       fe;
      logic       bk;
   } exp_t;
   exp_t exp_q[$];

   logic mon_on = 1'b0;
   int   rd_req = 0, rd_seen = 0, clr_req = 0, clr_seen = 0;

   always #4 clk = ~clk;

   async_char_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .smp_tick(smp_tick),
      .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .div_sel(div_sel),
      .rx_en(rx_en), .rd_ack(rd_ack), .err_clr(err_clr),
      .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
      .err_overrun(err_overrun), .err_frame(err_frame), .brk_det(brk_det)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: sole driver of rd_ack and err_clr
   always @(negedge clk) begin
      rd_ack  <= 1'b0;
      err_clr <= 1'b0;
      if (mon_on && rx_ready && !rd_ack) begin
         if (exp_q.size() == 0) begin
            chk("R5 unexpected character", 32'(rx_data), 32'hFFFF);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R2 data", 32'(rx_data), 32'(e.d));
            chk("R8 parity flag", 32'(err_parity), 32'(e.pe));
            chk("R7 framing flag", 32'(err_frame), 32'(e.fe));
            chk("R9 break flag", 32'(brk_det), 32'(e.bk));
            chk("R6 no overrun", 32'(err_overrun), 32'd0);
         end
         rd_ack  <= 1'b1;
         err_clr <= 1'b1;
      end else begin
         if (rd_req != rd_seen) begin
            rd_ack  <= 1'b1;
            rd_seen <= rd_req;
         end
         if (clr_req != clr_seen) begin
            err_clr  <= 1'b1;
            clr_seen <= clr_req;
         end
      end
   end

   function automatic int ratio_of(input logic [1:0] code);
      case (code)
         2'b01:   return 1;
         2'b10:   return 16;
         2'b11:   return 64;
         default: return 16;
      endcase
   endfunction

   task automatic tick_once();
      @(negedge clk) smp_tick = 1'b1;
      @(negedge clk) smp_tick = 1'b0;
   endtask

   task automatic send_bit(input logic v, input int n);
      rx_line = v;
      for (int i = 0; i < n; i++) tick_once();
   endtask

   task automatic set_fmt(input logic [1:0] l, input logic pe, input logic pev, input logic [1:0] dv);
      len_sel = l; par_en = pe; par_even = pev; div_sel = dv;
   endtask

   // push expectation (when push=1) and drive one frame followed by idle
   task automatic send_char(input logic [7:0] d, input logic bad_par, input logic stop_v,
                            input logic push);
      int   r, nb;
      logic [7:0] m;
      logic ones, pb, zero;
      exp_t e;
      r  = ratio_of(div_sel);
      nb = 5 + int'(len_sel);
      m  = d & 8'((1 << nb) - 1);
      ones = ^m;
      pb = (par_even ? ones : ~ones) ^ bad_par;
      zero = (m == 8'h00) && (!par_en || !pb) && !stop_v;
      e.d = m; e.pe = par_en && bad_par; e.fe = !stop_v; e.bk = zero;
      if (push) exp_q.push_back(e);
      send_bit(1'b0, r);
      for (int i = 0; i < nb; i++) send_bit(m[i], r);
      if (par_en) send_bit(pb, r);
      send_bit(stop_v, r);
      send_bit(1'b1, 2 * r + 4);
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", 32'(rx_ready), 0);
      chk("R1 data", 32'(rx_data), 0);
      chk("R1 flags", 32'({err_parity, err_overrun, err_frame, brk_det}), 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (3) @(negedge clk);
      mon_on = 1'b1;

      // R2 R3 R5: 1x, 8 bits, no parity
      set_fmt(2'b11, 1'b0, 1'b0, 2'b01);
      send_char(8'hA5, 1'b0, 1'b1, 1'b1);
      // R8 even parity, 7 bits, 16x
      set_fmt(2'b10, 1'b1, 1'b1, 2'b10);
      send_char(8'h5A, 1'b0, 1'b1, 1'b1);
      // R2 R3 5 bits zero-extended, odd parity, 64x
      set_fmt(2'b00, 1'b1, 1'b0, 2'b11);
      send_char(8'hF3, 1'b0, 1'b1, 1'b1);
      // R8 wrong parity, 6 bits odd, 16x
      set_fmt(2'b01, 1'b1, 1'b0, 2'b10);
      send_char(8'h2C, 1'b1, 1'b1, 1'b1);
      // R7 missing stop bit
      set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
      send_char(8'h81, 1'b0, 1'b0, 1'b1);
      // R9 break: all zero with even parity bit zero
      set_fmt(2'b11, 1'b1, 1'b1, 2'b10);
      send_char(8'h00, 1'b0, 1'b0, 1'b1);
      settle();
      chk("R5 queue drained", 32'(exp_q.size()), 0);

      // R4 glitch at 16x
      set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
      send_bit(1'b0, 3);
      send_bit(1'b1, 40);
      chk("R4 glitch ignored", 32'(rx_ready), 0);
      send_char(8'h3C, 1'b0, 1'b1, 1'b1);
      settle();
      chk("R4 frame after glitch", 32'(exp_q.size()), 0);

      // R3 divisor 00 accepts nothing
      mon_on = 1'b0;
      set_fmt(2'b11, 1'b0, 1'b0, 2'b00);
      send_char(8'h55, 1'b0, 1'b1, 1'b0);
      chk("R3 div00 no frame", 32'(rx_ready), 0);

      // R11 disabled for whole frame
      set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
      rx_en = 1'b0;
      send_char(8'h66, 1'b0, 1'b1, 1'b0);
      chk("R11 disabled no frame", 32'(rx_ready), 0);
      // R11 disable mid-frame
      rx_en = 1'b1;
      send_bit(1'b1, 4);
      send_bit(1'b0, 16);
      send_bit(1'b1, 16);
      send_bit(1'b0, 16);
      rx_en = 1'b0;
      send_bit(1'b1, 16);
      send_bit(1'b0, 16);
      send_bit(1'b1, 80);
      rx_en = 1'b1;
      send_bit(1'b1, 40);
      chk("R11 aborted frame dropped", 32'(rx_ready), 0);
      chk("R11 no flags", 32'({err_parity, err_overrun, err_frame, brk_det}), 0);

      // R6 overrun
      send_char(8'h11, 1'b0, 1'b1, 1'b0);
      chk("R5 ready after frame", 32'(rx_ready), 1);
      send_char(8'h22, 1'b0, 1'b1, 1'b0);
      chk("R6 overrun flag", 32'(err_overrun), 1);
      chk("R6 newer data kept", 32'(rx_data), 32'h22);
      rd_req++;
      settle();
      chk("R5 ready cleared by read", 32'(rx_ready), 0);
      chk("R10 overrun survives read", 32'(err_overrun), 1);
      clr_req++;
      settle();
      chk("R10 overrun cleared", 32'(err_overrun), 0);

      // R10 parity flag survives a later good character
      set_fmt(2'b11, 1'b1, 1'b1, 2'b10);
      send_char(8'h0F, 1'b1, 1'b1, 1'b0);
      rd_req++;
      settle();
      send_char(8'h77, 1'b0, 1'b1, 1'b0);
      chk("R10 parity sticky", 32'(err_parity), 1);
      chk("R10 good data", 32'(rx_data), 32'h77);
      rd_req++;
      clr_req++;
      settle();
      chk("R10 all cleared", 32'({err_parity, err_overrun, err_frame, brk_det}), 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule